// File: doc/BRIEF.md
# Comparator Output Filter with Edge Interrupts

This block cleans up the raw, asynchronous output of an analog comparator. The raw level is first brought into the bus clock domain. It is then sampled at a chosen rate and passed through a run-length filter. The filtered level is exported and also watched for transitions. Each transition direction latches its own sticky flag. The flags drive a single interrupt line through separate enable bits.

Samples come from one of two timing sources. In the first, an internal counter fires once every N bus clocks, where N is a programmable interval. In the second, each pulse of an external strobe fires a sample. An interval of zero in the counter mode turns the filter off, and the synchronized level then passes straight through. Software uses a small three-register interface to set the mode and the interval, to enable the interrupts, to clear flags by writing ones, and to read the current filtered level.

Top module: `edge_filter_cmp`

## Requirements
- R1: After reset, every register reads 0, `filt_out` is 0 and `irq` is 0.
- R2: The raw input passes through two synchronizer flops. With the filter bypassed, a level applied before clock edge n appears on `filt_out` after edge n+2.
- R3: In counter mode with interval P > 0, a write of P restarts the interval counter. Sampling edges then fall P, 2P, 3P... clocks after the edge that captured the write.
- R4: In counter mode with interval 0, `filt_out` follows the synchronized level one clock later, with no run counting.
- R5: In strobe mode (CTRL bit0 = 1) the interval register is ignored. Each clock with `sample_strobe` high is one sampling instant, and `filt_out` does not change without a strobe.
- R6: `filt_out` flips only at the third consecutive sample that differs from it. A sample equal to `filt_out` resets the count, and the output holds meanwhile.
- R7: A 0-to-1 change of `filt_out` sets the rise flag (STATUS bit0) one clock later. A 1-to-0 change sets the fall flag (STATUS bit1) one clock later.
- R8: Writing 1 to a flag bit of STATUS clears that flag. Writing 0 leaves it unchanged, and the flags are otherwise sticky.
- R9: When a flag is set by an edge and cleared by a write on the same clock edge, it ends up set.
- R10: `irq` = (rise flag AND CTRL bit1) OR (fall flag AND CTRL bit2). A flag with its enable at 0 leaves `irq` low.
- R11: The register map is: address 0 CTRL (bit0 strobe mode, bit1 rise enable, bit2 fall enable); address 1 interval (8 bits); address 2 STATUS (bit0 rise, bit1 fall, bit2 filtered level read-only, bits 7:3 read 0). Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_raw | input | 1 | Asynchronous comparator output |
| sample_strobe | input | 1 | External sampling pulse, synchronous to clk, used in strobe mode |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| filt_out | output | 1 | Filtered comparator level |
| irq | output | 1 | Edge interrupt request |

## Verification
A raw-input change driven just after edge n reaches `filt_out` at edge n+3 in bypass, and the matching flag and `irq` follow at edge n+4. A register write driven after edge n takes effect at edge n+1. In counter mode the bench works out the sampling edges from the write cycle and the interval, and expects the output flip at the third edge that is at least three edges after the input change. A strobe driven after edge s samples at edge s+1. The driver pushes each expected value tagged with its due cycle, and a monitor compares it at the falling clock edge of exactly that cycle.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
  localparam int ADR_CTRL = 0;
  localparam int ADR_PER  = 1;
  localparam int ADR_STAT = 2;

  localparam int CTRL_EXT = 0;
  localparam int CTRL_RIE = 1;
  localparam int CTRL_FIE = 2;

  localparam int STAT_RF  = 0;
  localparam int STAT_FF  = 1;
  localparam int STAT_LVL = 2;

  typedef struct packed {
    logic fie;
    logic rie;
    logic ext;
  } ctrl_t;
endpackage

// File: rtl/cfi_sync.sv
module cfi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_one
      assign ff_d = d;
    end else begin : g_chain
      assign ff_d = {ff_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/cfi_tick.sv
module cfi_tick #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic [PER_W-1:0] period,
  input  logic             restart,
  input  logic             strobe,
  output logic             tick,
  output logic             bypass
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] last;
  logic             wrap;

  assign last   = period - {{(PER_W-1){1'b0}}, 1'b1};
  assign bypass = !ext_mode && (period == '0);
  assign wrap   = !ext_mode && !bypass && (cnt_q == last);
  assign tick   = ext_mode ? strobe : wrap;

  always_comb begin
    cnt_d = cnt_q + {{(PER_W-1){1'b0}}, 1'b1};
    if (restart || ext_mode || bypass || wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfi_vote.sv
module cfi_vote #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic tick,
  input  logic bypass,
  output logic dout
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] run_q, run_d;
  logic          out_q, out_d;

  always_comb begin
    run_d = run_q;
    out_d = out_q;
    if (bypass) begin
      out_d = din;
      run_d = '0;
    end else if (tick) begin
      if (din == out_q) begin
        run_d = '0;
      end else if (run_q == RW'(RUN_LEN - 1)) begin
        out_d = din;
        run_d = '0;
      end else begin
        run_d = run_q + {{(RW-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      out_q <= 1'b0;
    end else begin
      run_q <= run_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/cfi_flags.sv
module cfi_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr_rise,
  input  logic clr_fall,
  input  logic en_rise,
  input  logic en_fall,
  output logic rise_flag,
  output logic fall_flag,
  output logic irq
);
  logic prev_q;
  logic rf_q, rf_d, ff_q, ff_d;
  logic ev_rise, ev_fall;

  assign ev_rise = lvl && !prev_q;
  assign ev_fall = !lvl && prev_q;

  always_comb begin
    rf_d = ev_rise || (rf_q && !clr_rise);
    ff_d = ev_fall || (ff_q && !clr_fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rf_q   <= 1'b0;
      ff_q   <= 1'b0;
    end else begin
      prev_q <= lvl;
      rf_q   <= rf_d;
      ff_q   <= ff_d;
    end
  end

  assign rise_flag = rf_q;
  assign fall_flag = ff_q;
  assign irq       = (rf_q && en_rise) || (ff_q && en_fall);
endmodule

// File: rtl/edge_filter_cmp.sv
module edge_filter_cmp
  import cfi_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 3,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw,
  input  logic              sample_strobe,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              filt_out,
  output logic              irq
);
  logic             rst_int_n;
  logic             sync_lvl;
  logic             tick, bypass;
  ctrl_t            ctrl_q, ctrl_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             wr_ctrl, wr_per, wr_stat;
  logic             clr_rise, clr_fall;
  logic             rise_flag, fall_flag;
  logic             mode_ext, en_rise, en_fall;

  cfi_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  cfi_sync #(.STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(rst_int_n), .d(cmp_raw), .q(sync_lvl)
  );

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));
  assign wr_per   = reg_wr && (reg_addr == ADDR_W'(ADR_PER));
  assign wr_stat  = reg_wr && (reg_addr == ADDR_W'(ADR_STAT));
  assign clr_rise = wr_stat && reg_wdata[STAT_RF];
  assign clr_fall = wr_stat && reg_wdata[STAT_FF];

  always_comb begin
    ctrl_d = ctrl_q;
    per_d  = per_q;
    if (wr_ctrl) begin
      ctrl_d.ext = reg_wdata[CTRL_EXT];
      ctrl_d.rie = reg_wdata[CTRL_RIE];
      ctrl_d.fie = reg_wdata[CTRL_FIE];
    end
    if (wr_per) per_d = reg_wdata[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      per_q  <= per_d;
    end
  end

  assign mode_ext = ctrl_q.ext;
  assign en_rise  = ctrl_q.rie;
  assign en_fall  = ctrl_q.fie;

  cfi_tick #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .ext_mode(mode_ext), .period(per_q),
    .restart(wr_per), .strobe(sample_strobe), .tick(tick), .bypass(bypass)
  );

  cfi_vote #(.RUN_LEN(RUN_LEN)) u_vote (
    .clk(clk), .rst_n(rst_int_n), .din(sync_lvl), .tick(tick),
    .bypass(bypass), .dout(filt_out)
  );

  cfi_flags u_flags (
    .clk(clk), .rst_n(rst_int_n), .lvl(filt_out),
    .clr_rise(clr_rise), .clr_fall(clr_fall),
    .en_rise(en_rise), .en_fall(en_fall),
    .rise_flag(rise_flag), .fall_flag(fall_flag), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADR_CTRL): begin
        reg_rdata[CTRL_EXT] = ctrl_q.ext;
        reg_rdata[CTRL_RIE] = ctrl_q.rie;
        reg_rdata[CTRL_FIE] = ctrl_q.fie;
      end
      ADDR_W'(ADR_PER):  reg_rdata[PER_W-1:0] = per_q;
      ADDR_W'(ADR_STAT): begin
        reg_rdata[STAT_RF]  = rise_flag;
        reg_rdata[STAT_FF]  = fall_flag;
        reg_rdata[STAT_LVL] = filt_out;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/edge_filter_cmp_chk.sv
module edge_filter_cmp_chk #(
  parameter int PER_W  = 8,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_ext,
  input logic [PER_W-1:0]  per_q,
  input logic              sample_strobe,
  input logic              sync_lvl,
  input logic              tick,
  input logic              filt_out,
  input logic              rise_flag,
  input logic              fall_flag,
  input logic              clr_rise,
  input logic              clr_fall,
  input logic              irq,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);
  logic chk_bypass;
  assign chk_bypass = !mode_ext && (per_q == '0);

  // R4
  p_bypass_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_bypass |=> (filt_out == $past(sync_lvl)));

  // R5
  p_ext_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ext && !sample_strobe) |=> $stable(filt_out));

  // R6
  p_hold_between_samples_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_bypass && !tick) |=> $stable(filt_out));

  // R7
  p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_out) |=> rise_flag);

  p_fall_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_out) |=> fall_flag);

  // R8
  p_rise_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_flag && !clr_rise) |=> rise_flag);

  p_fall_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_flag && !clr_fall) |=> fall_flag);

  // R10
  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_flag && !fall_flag) |-> !irq);

  // R11
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(2)) |-> (reg_rdata[DATA_W-1:3] == '0));
endmodule

bind edge_filter_cmp edge_filter_cmp_chk #(
  .PER_W(PER_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .mode_ext(mode_ext), .per_q(per_q),
  .sample_strobe(sample_strobe), .sync_lvl(sync_lvl), .tick(tick),
  .filt_out(filt_out), .rise_flag(rise_flag), .fall_flag(fall_flag),
  .clr_rise(clr_rise), .clr_fall(clr_fall), .irq(irq),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/edge_filter_cmp_bench.sv
`timescale 1ns/1ps
module edge_filter_cmp_bench;
  logic       clk = 1'b0;
  logic       rst_n, cmp_raw, sample_strobe, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       filt_out, irq;

  always #2.5 clk = ~clk;

  edge_filter_cmp u_edge_filter_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .sample_strobe(sample_strobe),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .filt_out(filt_out), .irq(irq)
  );

  typedef struct {
    int         due;
    int         sig;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   nchk = 0;
  int   nerr = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(string tag, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  task automatic expect_at(int due, int sig, logic [7:0] val, string tag);
    exp_t it;
    it.due = due; it.sig = sig; it.val = val; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: 0 = filt_out, 1 = irq, 2 = STATUS read data
  always @(negedge clk) begin
    logic [7:0] act;
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due <= cyc) begin
        case (sbq[i].sig)
          0:       act = {7'd0, filt_out};
          1:       act = {7'd0, irq};
          default: act = reg_rdata;
        endcase
        if (sbq[i].due < cyc) chk({sbq[i].tag, " (missed)"}, 8'hxx, sbq[i].val);
        else                  chk(sbq[i].tag, act, sbq[i].val);
        sbq.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_addr = 2'd2; reg_wdata = 8'h00;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    step(1);
    reg_addr = 2'd2;
  endtask

  task automatic pulse();
    sample_strobe = 1'b1;
    step(1);
    sample_strobe = 1'b0;
  endtask

  function automatic int first_tick(int w, int p, int r);
    int e;
    e = w + 1 + p;
    while (e < r + 3) e += p;
    return e;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int r, w, e, s;
    rst_n = 1'b0; cmp_raw = 1'b0; sample_strobe = 1'b0;
    reg_wr = 1'b0; reg_addr = 2'd2; reg_wdata = 8'h00;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    chk("R1 filt_out", {7'd0, filt_out}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd0, 8'h00, "R1 CTRL");
    rd(2'd1, 8'h00, "R1 interval");
    rd(2'd2, 8'h00, "R1 STATUS");
    rd(2'd3, 8'h00, "R11 address 3");

    // R2/R4 bypass path, R7 rise flag, R10 irq with enables on
    wr(2'd0, 8'h06);
    rd(2'd0, 8'h06, "R11 CTRL readback");
    r = cyc; cmp_raw = 1'b1;
    expect_at(r + 2, 0, 8'h00, "R2 not before third edge");
    expect_at(r + 3, 0, 8'h01, "R2 bypass latency");
    expect_at(r + 3, 2, 8'h04, "R11 level bit");
    expect_at(r + 4, 2, 8'h05, "R7 rise flag");
    expect_at(r + 3, 1, 8'h00, "R10 irq before flag");
    expect_at(r + 4, 1, 8'h01, "R10 irq on rise");
    step(6);

    // R8 write 0 no effect, then write 1 clears
    w = cyc;
    expect_at(w + 1, 2, 8'h05, "R8 write 0 keeps flag");
    expect_at(w + 1, 1, 8'h01, "R8 irq kept");
    wr(2'd2, 8'h00);
    w = cyc;
    expect_at(w + 1, 2, 8'h04, "R8 clear rise");
    expect_at(w + 1, 1, 8'h00, "R10 irq drops");
    wr(2'd2, 8'h01);
    step(2);

    // R7 fall flag through bypass (R4)
    r = cyc; cmp_raw = 1'b0;
    expect_at(r + 3, 0, 8'h00, "R4 bypass fall");
    expect_at(r + 3, 2, 8'h00, "R7 no flag yet");
    expect_at(r + 4, 2, 8'h02, "R7 fall flag");
    expect_at(r + 4, 1, 8'h01, "R10 irq on fall");
    step(6);
    w = cyc;
    expect_at(w + 1, 2, 8'h00, "R8 clear fall");
    wr(2'd2, 8'h02);
    step(2);

    // R10 enable combinations
    wr(2'd0, 8'h00);
    r = cyc; cmp_raw = 1'b1;
    expect_at(r + 4, 2, 8'h05, "R10 flag set disabled");
    expect_at(r + 4, 1, 8'h00, "R10 irq masked");
    step(6);
    w = cyc;
    expect_at(w + 1, 1, 8'h01, "R10 rise enable");
    wr(2'd0, 8'h02);
    w = cyc;
    expect_at(w + 1, 1, 8'h00, "R10 only fall enable");
    wr(2'd0, 8'h04);
    w = cyc;
    expect_at(w + 1, 2, 8'h04, "R8 clear both");
    wr(2'd2, 8'h03);
    step(2);

    // R9 set wins over same-edge clear
    r = cyc; cmp_raw = 1'b0;
    step(3);
    expect_at(r + 4, 2, 8'h02, "R9 set beats clear");
    wr(2'd2, 8'h02);
    step(3);
    w = cyc;
    expect_at(w + 1, 2, 8'h00, "R9 later clear");
    wr(2'd2, 8'h02);
    step(2);

    // R3/R6 counter mode interval 4
    w = cyc;
    wr(2'd1, 8'h04);
    rd(2'd1, 8'h04, "R11 interval readback");
    step(5);
    r = cyc; cmp_raw = 1'b1;
    e = first_tick(w, 4, r);
    expect_at(e + 7, 0, 8'h00, "R6 holds before third sample");
    expect_at(e + 8, 0, 8'h01, "R3 third sample at interval 4");
    expect_at(e + 9, 2, 8'h05, "R7 rise in counter mode");
    step(e + 12 - cyc);
    wr(2'd2, 8'h01);

    // R3 restart on interval write, interval 3
    w = cyc;
    wr(2'd1, 8'h03);
    step(2);
    r = cyc; cmp_raw = 1'b0;
    e = first_tick(w, 3, r);
    expect_at(e + 5, 0, 8'h01, "R6 holds at interval 3");
    expect_at(e + 6, 0, 8'h00, "R3 restart phase interval 3");
    expect_at(e + 7, 2, 8'h02, "R7 fall in counter mode");
    step(e + 10 - cyc);
    wr(2'd2, 8'h02);

    // R5 strobe mode, interval ignored
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    r = cyc; cmp_raw = 1'b1;
    expect_at(r + 3, 0, 8'h00, "R5 interval 0 ignored");
    expect_at(r + 10, 0, 8'h00, "R5 no strobe no change");
    step(10);
    pulse();
    pulse();
    cmp_raw = 1'b0;
    step(3);
    pulse();
    cmp_raw = 1'b1;
    step(3);
    pulse();
    pulse();
    expect_at(cyc, 0, 8'h00, "R6 run restarted by equal sample");
    step(1);
    s = cyc;
    expect_at(s, 0, 8'h00, "R6 two samples not enough");
    expect_at(s + 1, 0, 8'h01, "R5 strobe sample");
    expect_at(s + 2, 2, 8'h05, "R7 rise in strobe mode");
    pulse();
    step(4);

    done = 1;
    foreach (sbq[i]) begin
      nchk++; nerr++;
      $display("FAIL %s: actual=unchecked expected=%0h", sbq[i].tag, sbq[i].val);
    end
    summary();
    $finish;
  end
endmodule